// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block turns single requests from an internal master into timed cycles on a static asynchronous memory port with three banks. Each access runs through three phases: setup, strobe and hold. Address, chip select and write data are driven for the whole access. The active-low read-enable or write-enable is driven only in the strobe phase. The length of each phase is set by a configuration count. An external wait input can stretch the strobe. That input has an enable bit and a polarity bit, and it passes through a two-flop synchronizer before it has any effect.

The controller also drives the chip select of a neighbouring SDRAM port. That select is active by default. It is released only while an asynchronous chip select is active, so the two memory types are never selected together. Read data is captured on the last strobe clock. A one-cycle done pulse marks the end of each access.

Top module: `async_strobe_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0, all `mem_cs_n` bits, `mem_oe_n`, `mem_we_n` and `mem_wdata_oe` are inactive (1, 1, 1, 0), and `sdram_cs_n` is 0.
- R2: A request is taken only on a clock where `req_ready` is 1 and `req_bank` is 0, 1 or 2. A request made while busy, or one naming bank 3, starts nothing and changes no output.
- R3: The setup phase lasts `cfg_setup`+1 clocks. In it the selected chip select is low and both strobes are high.
- R4: With wait inactive, the strobe phase lasts `cfg_strobe`+1 clocks. `mem_oe_n` is low only in the strobe of a read, and `mem_we_n` is low only in the strobe of a write.
- R5: The hold phase lasts `cfg_hold`+1 clocks. In it the chip select stays low and both strobes are high.
- R6: Bit b of `mem_cs_n` is low exactly in the setup, strobe and hold clocks of an access to bank b. At most one bit is low at any time.
- R7: `sdram_cs_n` is 1 exactly in the clocks where some `mem_cs_n` bit is low, and 0 at all other times.
- R8: With `cfg_wait_en`=1, `mem_wait` is active when it equals `cfg_wait_pol` (1 = active high, 0 = active low). If wait is active from the start of the access and turns inactive in strobe clock t (counting from 0), the strobe lasts max(`cfg_strobe`+1, t+3) clocks.
- R9: With `cfg_wait_en`=0, `mem_wait` has no effect on the strobe length.
- R10: For reads, `rsp_rdata` takes the value of `mem_rdata` during the last strobe clock and holds it until the next read completes.
- R11: `rsp_done` is high for exactly one clock, the clock right after the last hold clock. In that clock `req_ready` is 1 again.
- R12: For the whole access, `mem_addr` carries the request address. During a write access, `mem_wdata` carries the request data and `mem_wdata_oe` is 1. `mem_wdata_oe` is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | CNT_W | Setup clocks minus one |
| cfg_strobe | input | CNT_W | Minimum strobe clocks minus one |
| cfg_hold | input | CNT_W | Hold clocks minus one |
| cfg_wait_en | input | 1 | Allows wait to stretch the strobe |
| cfg_wait_pol | input | 1 | Active level of the wait input |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank index 0..NUM_BANKS-1 |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Request write data |
| req_ready | output | 1 | Idle, so a request can be taken |
| rsp_done | output | 1 | One-clock end-of-access pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | DATA_W | Memory read data |
| mem_wait | input | 1 | Asynchronous wait from memory |
| mem_cs_n | output | NUM_BANKS | Active-low bank chip selects |
| mem_oe_n | output | 1 | Active-low read strobe |
| mem_we_n | output | 1 | Active-low write strobe |
| sdram_cs_n | output | 1 | Active-low SDRAM chip select |

## Verification
A stuck or miscounted phase counter shows up at once as a setup, strobe or hold length one or more clocks off. It also shifts the read capture, so `rsp_rdata` holds the value from the wrong strobe clock. A wrong wait decode or a synchronizer of the wrong depth changes the stretched strobe length by at least one clock within the same access. A bad bank or phase decode shows up on the first clock of an access, as a wrong chip select, a strobe outside its phase, or an SDRAM select that overlaps an asynchronous one. The bench sweeps every combination of phase counts from a small set, for both directions. It also sweeps the wait drop points under both polarities and compares every length with arithmetic.

// File: rtl/asc_pkg.sv
package asc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

endpackage

// File: rtl/asc_wait_sync.sv
module asc_wait_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/asc_sequencer.sv
module asc_sequencer
    import asc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 3,
    parameter int CNT_W     = 4,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_strobe,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic              cfg_wait_en,
    input  logic              cfg_wait_pol,
    input  logic              wait_sync,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output phase_e            phase,
    output logic              cur_write,
    output logic [BANK_W-1:0] cur_bank,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [DATA_W-1:0] cur_wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              ready
);
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;
    logic wait_act;
    logic cnt_zero;

    assign wait_act = cfg_wait_en && (wait_sync == cfg_wait_pol);
    assign cnt_zero = (s_q.cnt == '0);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid && (req_bank <= LAST_BANK)) begin
                    s_d.phase = PH_SETUP;
                    s_d.cnt   = cfg_setup;
                    s_d.wr    = req_write;
                    s_d.bank  = req_bank;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                end
            end
            PH_SETUP: begin
                if (cnt_zero) begin
                    s_d.phase = PH_STROBE;
                    s_d.cnt   = cfg_strobe;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                if (!cnt_zero) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (!wait_act) begin
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = cfg_hold;
                    if (!s_q.wr) s_d.rdata = mem_rdata;
                end
            end
            PH_HOLD: begin
                if (cnt_zero) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase     = s_q.phase;
    assign cur_write = s_q.wr;
    assign cur_bank  = s_q.bank;
    assign cur_addr  = s_q.addr;
    assign cur_wdata = s_q.wdata;
    assign rdata     = s_q.rdata;
    assign done      = s_q.done;
    assign ready     = (s_q.phase == PH_IDLE);

    // R2: a busy sequencer keeps its latched request
    a_r2_busy_keeps_request: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE) |=> $stable(s_q.addr) && $stable(s_q.bank));

    // R3: setup can only stay or advance into strobe
    a_r3_setup_next: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_SETUP) |=> (s_q.phase == PH_SETUP) || (s_q.phase == PH_STROBE));

    // R8: an active synchronized wait keeps the strobe running
    a_r8_wait_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_STROBE) && wait_act |=> (s_q.phase == PH_STROBE));

    // R11: done lasts a single clock
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R11: done comes only out of hold
    a_r11_done_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> $past(s_q.phase) == PH_HOLD);
endmodule

// File: rtl/asc_pin_decode.sv
module asc_pin_decode
    import asc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 3,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  phase_e               phase,
    input  logic                 cur_write,
    input  logic [BANK_W-1:0]    cur_bank,
    input  logic [ADDR_W-1:0]    cur_addr,
    input  logic [DATA_W-1:0]    cur_wdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 mem_wdata_oe,
    output logic [NUM_BANKS-1:0] mem_cs_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic                 sdram_cs_n
);
    logic busy;
    logic in_strobe;

    assign busy      = (phase != PH_IDLE);
    assign in_strobe = (phase == PH_STROBE);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        assign mem_cs_n[b] = !(busy && (cur_bank == BANK_W'(b)));
    end

    assign mem_oe_n     = !(in_strobe && !cur_write);
    assign mem_we_n     = !(in_strobe && cur_write);
    assign mem_wdata_oe = busy && cur_write;
    assign mem_addr     = cur_addr;
    assign mem_wdata    = cur_wdata;
    assign sdram_cs_n   = busy;

    // R6: never more than one bank selected
    a_r6_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));

    // R7: SDRAM select released while any bank is selected
    a_r7_sdram_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n != '1) |-> sdram_cs_n);

    // R4: a strobe always sits inside a selected access, and only one strobe
    a_r4_strobe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n) |-> (mem_cs_n != '1) && (mem_oe_n || mem_we_n));
endmodule

// File: rtl/async_strobe_ctrl.sv
module async_strobe_ctrl
    import asc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 16,
    parameter int NUM_BANKS = 3,
    parameter int CNT_W     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CNT_W-1:0]     cfg_setup,
    input  logic [CNT_W-1:0]     cfg_strobe,
    input  logic [CNT_W-1:0]     cfg_hold,
    input  logic                 cfg_wait_en,
    input  logic                 cfg_wait_pol,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [BANK_W-1:0]    req_bank,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rsp_done,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic                 mem_wdata_oe,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_wait,
    output logic [NUM_BANKS-1:0] mem_cs_n,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic                 sdram_cs_n
);
    logic              wait_sync;
    phase_e            phase;
    logic              cur_write;
    logic [BANK_W-1:0] cur_bank;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] cur_wdata;

    asc_wait_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (mem_wait),
        .sync_out (wait_sync)
    );

    asc_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_setup    (cfg_setup),
        .cfg_strobe   (cfg_strobe),
        .cfg_hold     (cfg_hold),
        .cfg_wait_en  (cfg_wait_en),
        .cfg_wait_pol (cfg_wait_pol),
        .wait_sync    (wait_sync),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_bank     (req_bank),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .mem_rdata    (mem_rdata),
        .phase        (phase),
        .cur_write    (cur_write),
        .cur_bank     (cur_bank),
        .cur_addr     (cur_addr),
        .cur_wdata    (cur_wdata),
        .rdata        (rsp_rdata),
        .done         (rsp_done),
        .ready        (req_ready)
    );

    asc_pin_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS)
    ) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase        (phase),
        .cur_write    (cur_write),
        .cur_bank     (cur_bank),
        .cur_addr     (cur_addr),
        .cur_wdata    (cur_wdata),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_wdata_oe (mem_wdata_oe),
        .mem_cs_n     (mem_cs_n),
        .mem_oe_n     (mem_oe_n),
        .mem_we_n     (mem_we_n),
        .sdram_cs_n   (sdram_cs_n)
    );

    // R11: ready returns together with done
    a_r11_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R12: write data drive only inside an access
    a_r12_wdata_oe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wdata_oe |-> (mem_cs_n != '1) && mem_oe_n);
endmodule

// File: tb/async_strobe_ctrl_bench.sv
`timescale 1ns/1ps
module async_strobe_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0]  cfg_setup = '0, cfg_strobe = '0, cfg_hold = '0;
    logic        cfg_wait_en = 1'b0, cfg_wait_pol = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_wdata_oe;
    logic [15:0] mem_rdata = '0;
    logic        mem_wait = 1'b0;
    logic [2:0]  mem_cs_n;
    logic        mem_oe_n, mem_we_n, sdram_cs_n;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    async_strobe_ctrl u_async_strobe_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
        .cfg_wait_en(cfg_wait_en), .cfg_wait_pol(cfg_wait_pol),
        .req_valid(req_valid), .req_write(req_write), .req_bank(req_bank),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata), .mem_wait(mem_wait),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .sdram_cs_n(sdram_cs_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle_checks(input string tag);
        chk(mem_cs_n == 3'b111, {tag, " R6 cs idle"}, mem_cs_n, 7);
        chk(sdram_cs_n == 1'b0, {tag, " R7 sdram idle"}, sdram_cs_n, 0);
        chk(mem_oe_n && mem_we_n, {tag, " R4 strobes idle"}, {mem_oe_n, mem_we_n}, 3);
        chk(mem_wdata_oe == 1'b0, {tag, " R12 oe idle"}, mem_wdata_oe, 0);
        chk(req_ready == 1'b1, {tag, " R2 ready idle"}, req_ready, 1);
    endtask

    // drop_at < 0: wait held inactive for the whole access
    task automatic do_access(input bit wr, input int bank, input logic [7:0] addr,
                             input logic [15:0] wd, input int s, input int st,
                             input int h, input int drop_at);
        int n_setup = 0, n_strobe = 0, n_hold = 0, guard = 0, exp_st;
        @(negedge clk);
        cfg_setup = 4'(s); cfg_strobe = 4'(st); cfg_hold = 4'(h);
        mem_wait  = (drop_at >= 0) ? cfg_wait_pol : ~cfg_wait_pol;
        req_valid = 1'b1; req_write = wr; req_bank = 2'(bank);
        req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        while (mem_cs_n != 3'b111 && guard < 200) begin
            guard++;
            chk(mem_cs_n == ~(3'b001 << bank), "R6 bank select", mem_cs_n, ~(3'b001 << bank) & 7);
            chk(sdram_cs_n == 1'b1, "R7 sdram released", sdram_cs_n, 1);
            chk(mem_addr == addr, "R12 address", mem_addr, addr);
            chk(mem_wdata_oe == wr, "R12 data drive", mem_wdata_oe, wr);
            if (wr) chk(mem_wdata == wd, "R12 write data", mem_wdata, wd);
            if (!mem_oe_n || !mem_we_n) begin
                chk(mem_oe_n == wr && mem_we_n == !wr, "R4 strobe kind",
                    {mem_oe_n, mem_we_n}, wr ? 2 : 1);
                mem_rdata = {addr, 8'(n_strobe)};
                if (drop_at >= 0 && n_strobe == drop_at) mem_wait = ~cfg_wait_pol;
                n_strobe++;
            end else if (n_strobe == 0) begin
                n_setup++;
            end else begin
                n_hold++;
            end
            @(negedge clk);
        end
        exp_st = st + 1;
        if (cfg_wait_en && drop_at >= 0 && drop_at + 3 > exp_st) exp_st = drop_at + 3;
        chk(n_setup == s + 1, "R3 setup length", n_setup, s + 1);
        chk(n_strobe == exp_st, (drop_at >= 0) ? (cfg_wait_en ? "R8 stretched strobe" : "R9 wait ignored")
                                               : "R4 strobe length", n_strobe, exp_st);
        chk(n_hold == h + 1, "R5 hold length", n_hold, h + 1);
        chk(rsp_done == 1'b1 && req_ready == 1'b1, "R11 done with ready", {rsp_done, req_ready}, 3);
        chk(sdram_cs_n == 1'b0, "R7 sdram back", sdram_cs_n, 0);
        if (!wr) chk(rsp_rdata == {addr, 8'(exp_st - 1)}, "R10 read capture", rsp_rdata, {addr, 8'(exp_st - 1)});
        mem_wait = ~cfg_wait_pol;
        @(negedge clk);
        chk(rsp_done == 1'b0, "R11 done single", rsp_done, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int vals[4] = '{0, 1, 2, 15};
        int idx = 0;
        logic [15:0] held;
        repeat (3) @(negedge clk);
        idle_checks("R1 reset");
        chk(rsp_done == 1'b0, "R1 done reset", rsp_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_checks("R1 after reset");

        // phase length sweep, wait disabled
        for (int wr = 0; wr < 2; wr++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int c = 0; c < 4; c++) begin
                        do_access(wr[0], idx % 3, 8'(idx * 7 + 3), 16'(idx * 321 + 5),
                                  vals[a], vals[b], vals[c], -1);
                        idx++;
                    end

        // R8: wait stretches under both polarities
        cfg_wait_en = 1'b1;
        for (int p = 0; p < 2; p++) begin
            cfg_wait_pol = p[0];
            mem_wait = ~cfg_wait_pol;
            for (int st = 0; st < 5; st += 4)
                for (int d = 0; d < 10; d += 3)
                    do_access(1'b0, (p + d) % 3, 8'(40 + d + st), 16'h0, 1, st, 0, d);
        end
        // R8: write stretched too
        do_access(1'b1, 1, 8'h77, 16'hBEEF, 0, 0, 1, 6);

        // R9: wait disabled, active wait ignored
        cfg_wait_en = 1'b0;
        for (int p = 0; p < 2; p++) begin
            cfg_wait_pol = p[0];
            do_access(1'b0, 2, 8'h91, 16'h0, 0, 1, 0, 7);
        end
        cfg_wait_pol = 1'b1;
        mem_wait = 1'b0;

        // R2: request while busy is ignored
        held = rsp_rdata;
        @(negedge clk);
        cfg_setup = 4'd0; cfg_strobe = 4'd2; cfg_hold = 4'd0;
        req_valid = 1'b1; req_write = 1'b1; req_bank = 2'd0; req_addr = 8'h3C; req_wdata = 16'h1234;
        @(negedge clk);
        req_addr = 8'hEE; req_bank = 2'd1; req_wdata = 16'hFFFF;
        for (int k = 0; k < 3; k++) begin
            chk(mem_addr == 8'h3C && mem_cs_n == 3'b110, "R2 busy request ignored",
                mem_addr, 8'h3C);
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(mem_cs_n == 3'b111 && sdram_cs_n == 1'b0, "R2 no second access", mem_cs_n, 7);
        end
        chk(rsp_rdata == held, "R10 rdata held over write", rsp_rdata, held);

        // R2: bank index 3 is not taken
        req_valid = 1'b1; req_bank = 2'd3; req_write = 1'b0; req_addr = 8'h55;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            idle_checks("R2 bank 3");
        end
        req_valid = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule